// File: doc/BRIEF.md
# Condition-Driven Vector Truncation Controller

This block walks a vector operation through its elements in ascending order, one element per handshake. Each element that the predicate mask enables gets its 4-bit condition result back from the datapath and tests one bit of it. The loop ends at the first element whose selected bit fails the test. That element and everything above it are dropped, and the block reports a shortened vector length. If no element fails, the length comes back unchanged.

For each element it accepts, the controller tells the datapath whether to write the element's result and whether to write its condition field. It offers three variants. The cut can exclude the failing element or include it. An ordinary mode records conditions. A compare-only mode writes condition fields and never writes results. A length of zero is a legal outcome: later vector work then becomes a no-op.

Top module: `ffirst_loop_ctrl`

## Requirements
- R1: After reset, `done`, `elem_ready`, `res_we` and `cr_we` are 0 and `new_vl` is 0. A `start` while idle captures `vl_in` (clamped to MAX_VL), `pred_mask` and the mode inputs. A `start` while a loop is running is ignored.
- R2: Enabled elements are offered strictly in ascending index order, starting at the lowest enabled index. `elem_idx` names the element being offered. `elem_ready` is 1 exactly while the loop runs. An element is consumed only in a cycle where both `elem_valid` and `elem_ready` are 1.
- R3: The element's test fails when `elem_cr[cr_sel]` equals `inv`, with `cr_sel` indexing bits 0..3 of `elem_cr`.
- R4: On a failing element, `done` rises after that clock edge and `new_vl` equals the failing index, unless the inclusive cut applies. With the exclusive cut, neither write enable is asserted for the failing element.
- R5: When `incl`=1 and `rec`=0, the cut is inclusive: `new_vl` equals the failing index plus one, and the failing element's write enables behave as for a passing element. When `rec`=1, `incl` has no effect.
- R6: A failure at element 0 with the exclusive cut yields `new_vl`=0 with `done`=1.
- R7: When no enabled element below the length fails, `new_vl` equals the captured length. `done` rises after the edge that consumes the last enabled element. The length is never shortened without a failed test.
- R8: Elements whose `pred_mask` bit is 0 are skipped. They are never offered, never tested, and have no write enable.
- R9: With `cmp_only`=1, `res_we` is never asserted and `cr_we` is asserted for every kept element.
- R10: For a kept element with `cmp_only`=0, `res_we` is 1, and `cr_we` equals `rec`.
- R11: When the captured length is 0, or no element below it is enabled, `done` is 1 one cycle after `start` and `new_vl` equals the captured length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a loop (honoured only when idle) |
| vl_in | input | LEN_W | Vector length for this loop |
| pred_mask | input | MAX_VL | Per-element enable mask |
| inv | input | 1 | Bit value that counts as a failure |
| cr_sel | input | 2 | Selects the tested bit of the condition field |
| incl | input | 1 | Keep the failing element in the new length |
| rec | input | 1 | Record mode: condition fields written, inclusive cut disabled |
| cmp_only | input | 1 | Write condition fields only, never results |
| elem_valid | input | 1 | Condition result for `elem_idx` is present |
| elem_cr | input | 4 | Condition result of the offered element |
| elem_ready | output | 1 | Loop running, element may be consumed |
| elem_idx | output | IDX_W | Index of the offered element |
| res_we | output | 1 | Write the element's result this cycle |
| cr_we | output | 1 | Write the element's condition field this cycle |
| new_vl | output | LEN_W | Resulting vector length, valid with `done` |
| done | output | 1 | Loop finished; held until the next accepted start |

## Verification
The bench builds the block with its default MAX_VL of 64. At that size, a full-length pass reaches the top index 63 and a `new_vl` of 64, which needs the extra length bit. A `vl_in` above 64 checks the clamp. The directed cases place failures at element 0, in the middle, and on a masked-out index. They also insert idle cycles in the handshake and pulse `start` mid-loop.

// File: rtl/ffirst_pkg.sv
// Package: shared types for the condition-driven truncation controller.
// Assumes: the condition field is 4 bits and the bit selector is 2 bits.
package ffirst_pkg;

    localparam int CR_W  = 4;
    localparam int SEL_W = 2;

    // Mode bits captured at the start of a loop.
    typedef struct packed {
        logic             inv;
        logic [SEL_W-1:0] sel;
        logic             incl;
        logic             rec;
        logic             cmp_only;
    } ff_mode_t;

endpackage

// File: rtl/ff_cond_test.sv
// ff_cond_test: picks one bit of an element's condition field and reports
// whether the test on it fails (the bit equals the invert flag).
// Assumes: the selector is always in range for the field width.
module ff_cond_test
    import ffirst_pkg::*;
(
    input  logic [CR_W-1:0]  cr,
    input  logic [SEL_W-1:0] sel,
    input  logic             inv,
    output logic             fail
);

    logic picked;

    // Select the tested bit and compare it with the failure polarity.
    always_comb begin
        picked = cr[sel];
        fail   = (picked == inv);
    end

endmodule

// File: rtl/ff_elem_seq.sv
// ff_elem_seq: finds the lowest predicate-enabled element index at or above
// a starting point and below the vector length.
// Assumes: from and len never exceed MAX_VL.
module ff_elem_seq #(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  from,
    output logic              found,
    output logic [IDX_W-1:0]  nxt
);

    logic [MAX_VL-1:0] elig;

    // One eligibility bit per element: enabled, not below the start, inside the length.
    for (genvar g = 0; g < MAX_VL; g++) begin : g_elig
        assign elig[g] = mask[g] && (LEN_W'(g) >= from) && (LEN_W'(g) < len);
    end

    // Priority encoder: the lowest eligible index wins.
    always_comb begin
        found = 1'b0;
        nxt   = '0;
        for (int i = MAX_VL - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                nxt   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ff_len_calc.sv
// ff_len_calc: forms the truncated length from the failing index and the
// effective inclusive flag.
// Assumes: idx is below the captured length when fail is set.
module ff_len_calc #(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             incl_eff,
    output logic [LEN_W-1:0] cut_len
);

    // Exclusive cut keeps elements below idx; inclusive also keeps idx.
    always_comb begin
        cut_len = {1'b0, idx} + LEN_W'(incl_eff);
    end

endmodule

// File: rtl/ffirst_loop_ctrl.sv
// ffirst_loop_ctrl: steps through the enabled elements of a vector in order,
// tests each element's condition result, and stops at the first failure with
// a truncated length. It also drives the per-element write enables.
// Assumes: the datapath holds elem_cr stable while elem_valid is high and
// elem_ready is low; vl_in above MAX_VL is clamped.
module ffirst_loop_ctrl
    import ffirst_pkg::*;
#(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  vl_in,
    input  logic [MAX_VL-1:0] pred_mask,
    input  logic              inv,
    input  logic [1:0]        cr_sel,
    input  logic              incl,
    input  logic              rec,
    input  logic              cmp_only,
    input  logic              elem_valid,
    input  logic [3:0]        elem_cr,
    output logic              elem_ready,
    output logic [IDX_W-1:0]  elem_idx,
    output logic              res_we,
    output logic              cr_we,
    output logic [LEN_W-1:0]  new_vl,
    output logic              done
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_VL);

    logic              busy_q, done_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  vl_q, new_vl_q;
    logic [MAX_VL-1:0] mask_q;
    ff_mode_t          mode_q, mode_in;

    logic              launch, accept, test_fail, fail, keep, incl_eff;
    logic [LEN_W-1:0]  vl_clamped, seq_len, seq_from, cut_len;
    logic [MAX_VL-1:0] seq_mask;
    logic              seq_found;
    logic [IDX_W-1:0]  seq_nxt;

    // Gather the mode inputs and clamp the requested length.
    always_comb begin
        mode_in    = '{inv: inv, sel: cr_sel, incl: incl, rec: rec, cmp_only: cmp_only};
        vl_clamped = (vl_in > LEN_MAX) ? LEN_MAX : vl_in;
    end

    // Handshake and keep/discard decisions for the offered element.
    always_comb begin
        launch   = start && !busy_q;
        accept   = busy_q && elem_valid;
        fail     = accept && test_fail;
        incl_eff = mode_q.incl && !mode_q.rec;
        keep     = !test_fail || incl_eff;
        res_we   = accept && keep && !mode_q.cmp_only;
        cr_we    = accept && keep && (mode_q.rec || mode_q.cmp_only);
    end

    // Sequencer search inputs: from zero on launch, past the current element while running.
    always_comb begin
        seq_mask = busy_q ? mask_q : pred_mask;
        seq_len  = busy_q ? vl_q : vl_clamped;
        seq_from = busy_q ? ({1'b0, idx_q} + LEN_W'(1)) : '0;
    end

    ff_cond_test u_test (
        .cr   (elem_cr),
        .sel  (mode_q.sel),
        .inv  (mode_q.inv),
        .fail (test_fail)
    );

    ff_elem_seq #(.MAX_VL(MAX_VL)) u_seq (
        .mask  (seq_mask),
        .len   (seq_len),
        .from  (seq_from),
        .found (seq_found),
        .nxt   (seq_nxt)
    );

    ff_len_calc #(.MAX_VL(MAX_VL)) u_len (
        .idx      (idx_q),
        .incl_eff (incl_eff),
        .cut_len  (cut_len)
    );

    // Loop state: launch, advance past passing elements, finish on failure or exhaustion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            idx_q    <= '0;
            vl_q     <= '0;
            new_vl_q <= '0;
            mask_q   <= '0;
            mode_q   <= '0;
        end else if (launch) begin
            vl_q     <= vl_clamped;
            mask_q   <= pred_mask;
            mode_q   <= mode_in;
            new_vl_q <= vl_clamped;
            idx_q    <= seq_nxt;
            busy_q   <= seq_found;
            done_q   <= !seq_found;
        end else if (accept) begin
            if (test_fail) begin
                busy_q   <= 1'b0;
                done_q   <= 1'b1;
                new_vl_q <= cut_len;
            end else if (seq_found) begin
                idx_q <= seq_nxt;
            end else begin
                busy_q   <= 1'b0;
                done_q   <= 1'b1;
                new_vl_q <= vl_q;
            end
        end
    end

    assign elem_ready = busy_q;
    assign elem_idx   = idx_q;
    assign new_vl     = new_vl_q;
    assign done       = done_q;

    AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        elem_ready |-> !done) else $error("ready while done"); // R2
    AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !test_fail) |=> (!busy_q || (elem_idx > $past(elem_idx)))) else $error("index not ascending"); // R2
    AST_WE_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we || cr_we) |-> (mask_q[elem_idx] && ({1'b0, elem_idx} < vl_q))) else $error("write on skipped element"); // R8
    AST_CMP_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && mode_q.cmp_only) |-> !res_we) else $error("result write in compare-only"); // R9
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_vl <= vl_q)) else $error("length grew"); // R7
    AST_CUT_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && (new_vl != vl_q)) |-> $past(fail)) else $error("cut without failure"); // R4
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && !accept) |=> $stable(vl_q)) else $error("start taken while busy"); // R1

endmodule

// File: tb/tb_ffirst_loop_ctrl.sv
module tb_ffirst_loop_ctrl;

    localparam int MAX_VL = 64;
    localparam int IDX_W  = $clog2(MAX_VL);
    localparam int LEN_W  = IDX_W + 1;
    localparam int NONE   = 999;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  vl_in = '0;
    logic [MAX_VL-1:0] pred_mask = '0;
    logic              inv = 1'b0;
    logic [1:0]        cr_sel = '0;
    logic              incl = 1'b0, rec = 1'b0, cmp_only = 1'b0;
    logic              elem_valid = 1'b0;
    logic [3:0]        elem_cr = '0;
    logic              elem_ready, res_we, cr_we, done;
    logic [IDX_W-1:0]  elem_idx;
    logic [LEN_W-1:0]  new_vl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ffirst_loop_ctrl #(.MAX_VL(MAX_VL)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] make_cr(input int i, input logic [1:0] s,
                                           input logic iv, input bit failing);
        logic [3:0] c;
        c    = {i[1:0] ^ 2'b10, i[0], ~i[0]};
        c[s] = failing ? iv : ~iv;
        return c;
    endfunction

    // One loop: fail_at is the element given a failing condition (NONE for none),
    // gap inserts an idle cycle before each element, poke pulses start mid-loop.
    task automatic run_case(input string req, input int vl, input logic [MAX_VL-1:0] m,
                            input logic iv, input logic [1:0] s, input logic inc,
                            input logic rc, input logic cmp, input int fail_at,
                            input bit gap, input bit poke);
        int  eff_vl, exp_len;
        bit  inc_eff, stopped;
        eff_vl  = (vl > MAX_VL) ? MAX_VL : vl;
        inc_eff = inc && !rc;
        exp_len = eff_vl;
        stopped = 0;
        @(negedge clk);
        start = 1'b1; vl_in = LEN_W'(vl); pred_mask = m;
        inv = iv; cr_sel = s; incl = inc; rec = rc; cmp_only = cmp;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < eff_vl && !stopped; i++) begin
            bit isf, kp;
            if (!m[i]) continue;
            if (gap) begin
                elem_valid = 1'b0;
                #1;
                check(elem_ready == 1'b1 && res_we == 1'b0, {req, " ready idle"}, elem_ready, 1);
                @(negedge clk);
            end
            isf = (i == fail_at);
            kp  = !isf || inc_eff;
            elem_valid = 1'b1;
            elem_cr    = make_cr(i, s, iv, isf);
            if (poke) begin
                start = 1'b1; vl_in = LEN_W'(3);
            end
            #1;
            check(elem_idx == IDX_W'(i), {req, " idx"}, elem_idx, i);
            check(res_we == (kp && !cmp), {req, " res_we"}, res_we, kp && !cmp);
            check(cr_we == (kp && (rc || cmp)), {req, " cr_we"}, cr_we, kp && (rc || cmp));
            @(negedge clk);
            start = 1'b0;
            if (isf) begin
                stopped = 1;
                exp_len = i + int'(inc_eff);
            end
        end
        elem_valid = 1'b0;
        #1;
        check(done == 1'b1 && elem_ready == 1'b0, {req, " done"}, done, 1);
        check(new_vl == LEN_W'(exp_len), {req, " new_vl"}, new_vl, exp_len);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 0 && elem_ready == 0 && res_we == 0 && cr_we == 0 && new_vl == 0,
              "R1 reset", done, 0);
        rst_n = 1'b1;
        // R7 R10: all pass, results written, no condition writes
        run_case("R7", 8, {MAX_VL{1'b1}}, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, NONE, 0, 0);
        // R4 R10: exclusive cut in record mode
        run_case("R4", 10, {MAX_VL{1'b1}}, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 5, 0, 0);
        // R5: inclusive cut
        run_case("R5", 10, {MAX_VL{1'b1}}, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 5, 0, 0);
        // R5: inclusive ignored when record set
        run_case("R5 rec", 10, {MAX_VL{1'b1}}, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 5, 0, 0);
        // R6: element 0 fails, length zero
        run_case("R6", 12, {MAX_VL{1'b1}}, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 0, 0, 0);
        // R8: failing condition on a masked element is not tested
        run_case("R8", 6, 64'hFFFF_FFFF_FFFF_FFF7, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 3, 0, 0);
        // R8: sparse mask, failure on an enabled element
        run_case("R8 sparse", 20, 64'h0000_0000_0005_5A50, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 14, 0, 0);
        // R9: compare-only with inclusive cut
        run_case("R9", 9, {MAX_VL{1'b1}}, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 4, 0, 0);
        // R11: zero length and no enabled element
        run_case("R11 zero", 0, {MAX_VL{1'b1}}, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, NONE, 0, 0);
        run_case("R11 nomask", 10, '0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, NONE, 0, 0);
        // R1 R3: clamp above MAX_VL, full length, inverted polarity on bit 3
        run_case("R1 clamp R3", 100, {MAX_VL{1'b1}}, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, NONE, 0, 0);
        // R3: failure on the top element
        run_case("R3 top", 64, {MAX_VL{1'b1}}, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 63, 0, 0);
        // R2: idle cycles in the handshake
        run_case("R2 gap", 7, 64'h0000_0000_0000_006D, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, NONE, 1, 0);
        // R1: start while busy ignored
        run_case("R1 busy", 9, {MAX_VL{1'b1}}, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 7, 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule